// File: doc/BRIEF.md
# Pseudo-Random Central Bus Arbiter

This block is the single decision point for a shared bus with several initiators. Each initiator has its own request input and gets its own grant output back. An initiator raises its request when it wants the bus. It may put control signals on the bus only while its own grant is high. The arbiter hands the bus to one initiator at a time. It keeps the grant with that owner for as long as the owner holds its request, so a transaction may last many cycles.

When the bus is free and a single initiator is asking, that initiator wins. When several are asking in the same cycle, the winner is not chosen by a fixed rank. A 16-bit linear feedback shift register steps once per clock and supplies a starting position. The first requesting initiator found at or after that position, wrapping around the end of the vector, takes the bus. Initiators that lose keep their request high and wait. After the owner lets go there is one idle cycle, and a new pick is made in that cycle.

Top module: `rand_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every grant line is low. Reset loads the shift register with the seed 16'hACE1.
- R2: In every cycle the grant vector is either all zero or has exactly one bit set.
- R3: If the grant vector is zero and exactly one request bit is high in a cycle, the grant bit of that same index is high in the next cycle.
- R4: If the grant vector is zero and two or more request bits are high, the next grant goes to a winner picked as follows. Take a starting index S from the current shift-register value: S is its low clog2(N_INIT) bits, reduced by N_INIT if they reach N_INIT. The winner is the first set request bit at index S, S+1, ... modulo N_INIT.
- R5: While the current owner keeps its request high, its grant stays high and unchanged, whatever the other request lines do.
- R6: In the cycle after the owner's request is seen low, the grant vector is all zero, even when other initiators are requesting.
- R7: In that all-zero cycle the arbiter picks again, and the new grant appears in the cycle after it.
- R8: A grant bit is set only if the request of the same index was high in the cycle before.
- R9: The shift register advances on every clock edge outside reset. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}, and this holds whether or not a pick is made. Over a long run with contention, every initiator wins at least one contended pick.
- R10: With no request high and the bus free, the grant vector stays all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_INIT | One request line per initiator |
| grant | output | N_INIT | Registered one-hot grant, all zero when the bus is free |

## Verification
A shift register that is off by even one step moves the starting index. The first contended pick after reset then goes to the wrong initiator, and this shows on the grant port one cycle after the contention begins. A fault in the hold or release logic shows within one cycle of the owner's request edge: either the grant vanishes while the request is still high, or it lingers after the request drops, or a waiting initiator takes the bus with no idle cycle. A pick that breaks one-hot or goes to a line that was not requesting shows in the cycle right after that pick.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Bus phase derived from the grant register
  typedef enum logic {
    PH_FREE = 1'b0,
    PH_HELD = 1'b1
  } arb_phase_e;

  // Wrap a value in [0, 2n) into [0, n)
  function automatic int unsigned wrap_idx(input int unsigned v, input int unsigned n);
    return (v >= n) ? v - n : v;
  endfunction

endpackage

// File: rtl/arb_lfsr.sv
module arb_lfsr #(
  parameter int          STATE_W = 16,
  parameter logic [STATE_W-1:0] SEED = 16'hACE1,
  parameter logic [STATE_W-1:0] TAPS = 16'hB400,
  parameter int          OUT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);

  logic [STATE_W-1:0] state_q;
  logic               fb;

  assign fb  = ^(state_q & TAPS);
  assign rnd = state_q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[STATE_W-2:0], fb};
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int N_INIT = 4,
  parameter int IDX_W  = 2
) (
  input  logic [N_INIT-1:0] req,
  input  logic [IDX_W-1:0]  rnd,
  output logic [N_INIT-1:0] win,
  output logic              any
);

  localparam bit POW2 = ((1 << IDX_W) == N_INIT);

  logic [IDX_W-1:0] start;

  generate
    if (POW2) begin : g_direct
      assign start = rnd;
    end else begin : g_fold
      assign start = IDX_W'(wrap_idx(int'(rnd), N_INIT));
    end
  endgenerate

  always_comb begin
    logic             found;
    logic [IDX_W-1:0] idx;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N_INIT; k++) begin
      idx = IDX_W'(wrap_idx(int'(start) + k, N_INIT));
      if (!found && req[idx]) begin
        win[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
  import arb_pkg::*;
#(
  parameter int N_INIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_INIT-1:0] req,
  input  logic [N_INIT-1:0] win,
  input  logic              any,
  output logic [N_INIT-1:0] grant
);

  logic [N_INIT-1:0] grant_q;
  logic [N_INIT-1:0] grant_d;
  arb_phase_e        phase;
  logic              owner_keeps;

  assign phase       = (|grant_q) ? PH_HELD : PH_FREE;
  assign owner_keeps = |(grant_q & req);

  always_comb begin
    grant_d = grant_q;
    unique case (phase)
      PH_FREE: grant_d = any ? win : '0;
      PH_HELD: if (!owner_keeps) grant_d = '0;
      default: grant_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= grant_d;
  end

  assign grant = grant_q;

endmodule

// File: rtl/rand_bus_arbiter.sv
module rand_bus_arbiter #(
  parameter int          N_INIT  = 4,
  parameter int          LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_INIT-1:0] req,
  output logic [N_INIT-1:0] grant
);

  localparam int IDX_W = (N_INIT > 1) ? $clog2(N_INIT) : 1;

  logic [IDX_W-1:0]  rnd;
  logic [N_INIT-1:0] win;
  logic              any;

  arb_lfsr #(
    .STATE_W (LFSR_W),
    .SEED    (SEED),
    .TAPS    (TAPS),
    .OUT_W   (IDX_W)
  ) u_lfsr (
    .clk (clk),
    .rst (rst),
    .rnd (rnd)
  );

  arb_pick #(
    .N_INIT (N_INIT),
    .IDX_W  (IDX_W)
  ) u_pick (
    .req (req),
    .rnd (rnd),
    .win (win),
    .any (any)
  );

  arb_grant_ctrl #(
    .N_INIT (N_INIT)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .win   (win),
    .any   (any),
    .grant (grant)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_INIT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_INIT-1:0] req,
  input logic [N_INIT-1:0] grant
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2

  AST_SOLE_REQ_WINS: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(grant) == '0) && $onehot($past(req)) |-> grant == $past(req)); // R3

  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    past_ok && (($past(grant) & $past(req)) != '0) |-> grant == $past(grant)); // R5

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(grant) != '0) && (($past(grant) & $past(req)) == '0) |-> grant == '0); // R6

  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    past_ok && (grant != '0) |-> (grant & $past(req)) != '0); // R8

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(grant) == '0) && ($past(req) == '0) |-> grant == '0); // R10

endmodule

bind rand_bus_arbiter arb_checker #(.N_INIT(N_INIT)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req   (req),
  .grant (grant)
);

// File: tb/rand_bus_arbiter_test.sv
module rand_bus_arbiter_test;

  localparam int          N    = 4;
  localparam int          IW   = 2;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;

  always #5 clk = ~clk;

  rand_bus_arbiter uut (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant)
  );

  int    checks = 0;
  int    fails  = 0;
  int    wins [N];
  bit    done   = 0;

  logic [15:0]  m_lfsr;
  logic [N-1:0] m_grant;
  logic [N-1:0] m_req;
  string        m_tag;
  bit           m_was_release;

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Expected winner from the R4 rule
  function automatic logic [N-1:0] exp_pick(input logic [N-1:0] r, input logic [15:0] l);
    int s;
    logic [N-1:0] w;
    s = int'(l[IW-1:0]);
    if (s >= N) s -= N;
    w = '0;
    for (int k = 0; k < N; k++) begin
      int i;
      i = (s + k) % N;
      if (r[i]) begin
        w[i] = 1'b1;
        return w;
      end
    end
    return w;
  endfunction

  // Reference model, updated at each rising edge
  always @(posedge clk) begin
    m_req = req;
    if (rst) begin
      m_lfsr        = SEED;
      m_grant       = '0;
      m_tag         = "R1";
      m_was_release = 0;
    end else begin
      if (m_grant == '0) begin
        if (req == '0)               m_tag = "R10";
        else if ($countones(req) == 1) m_tag = m_was_release ? "R7/R3" : "R3";
        else                          m_tag = m_was_release ? "R7/R4/R9" : "R4/R9";
        m_grant = exp_pick(req, m_lfsr);
        if ($countones(req) > 1)
          for (int i = 0; i < N; i++) if (m_grant[i]) wins[i]++;
        m_was_release = 0;
      end else if ((m_grant & req) != '0) begin
        m_tag = "R5";
        m_was_release = 0;
      end else begin
        m_grant = '0;
        m_tag = "R6";
        m_was_release = 1;
      end
      m_lfsr = {m_lfsr[14:0], ^(m_lfsr & TAPS)};
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(grant == m_grant, m_tag, grant, m_grant);
      check($onehot0(grant), "R2", grant, m_grant);
      if (!rst && grant != '0)
        check((grant & m_req) != '0, "R8", grant & m_req, grant);
    end
  end

  initial begin
    int unsigned seed_dummy;
    for (int i = 0; i < N; i++) wins[i] = 0;
    seed_dummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    check(grant == '0, "R1", grant, '0);
    rst = 1'b0;

    // Contention right after reset: depends on the seed (R1, R4)
    req = '1;
    repeat (3) @(negedge clk);
    req = '0;
    repeat (3) @(negedge clk);

    // Single requesters (R3, R5, R6, R10)
    for (int i = 0; i < N; i++) begin
      req = N'(1) << i;
      repeat (3) @(negedge clk);
      req = '0;
      repeat (2) @(negedge clk);
    end

    // Owner drops while others wait: free cycle then re-pick (R6, R7)
    req = '1;
    for (int r = 0; r < N; r++) begin
      repeat (3) @(negedge clk);
      req = req & ~grant;
    end
    repeat (4) @(negedge clk);

    // Constrained random traffic
    for (int c = 0; c < 6000; c++) begin
      logic [N-1:0] nr;
      nr = req;
      for (int i = 0; i < N; i++) begin
        if (grant[i]) begin
          if ($urandom_range(3) == 0) nr[i] = 1'b0;
        end else if (!req[i]) begin
          if ($urandom_range(2) == 0) nr[i] = 1'b1;
        end
      end
      req = nr;
      @(negedge clk);
    end
    req = '0;
    repeat (3) @(negedge clk);

    // R9: no fixed ranking, every initiator wins some contended pick
    for (int i = 0; i < N; i++)
      check(wins[i] > 0, "R9", N'(wins[i]), N'(1));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule